// File: doc/BRIEF.md
# Socket Activity LED Controller

This block lights one indicator output per card socket whenever the card in that socket shows bus traffic. The signal that counts as traffic depends on the card's bus type. On a 16-bit card it is the combined ready/interrupt line. On a 32-bit card it is any of the three transaction lines: frame, initiator ready and request. Each sighting of traffic loads a per-socket hold timer with the full hold period. The indicator stays lit until that timer drains, so steady traffic keeps it lit without a gap.

Per-socket inputs are asynchronous to the block clock and pass through a two-stage synchronizer before any decision. Three global conditions force every indicator dark at once so an LED never appears frozen while the clock is about to stop: suspend, a pending clock-stop request, and the function being in light or deep sleep (D1 or D2). These conditions also empty the hold timers. Once a condition clears, an indicator lights again only after fresh traffic. The hold period is `HOLD_MS` milliseconds of `CYC_PER_MS` clock cycles each.

Top module: `sled_ctrl`

## Requirements
- R1: A synchronous active-high `rst` clears every hold timer, and `led` reads all zeros on the first clock edge after `rst` is sampled high.
- R2: A socket is live only while `card_present`=1, `card_powered`=1 and `card_in_reset`=0 (all after synchronization). A socket that is not live never lights, and if it stops being live during a hold its LED goes dark.
- R3: With `card_is_32`=0 (16-bit card), traffic is `card_rdy_irq_n`=0. The frame, initiator-ready and request lines have no effect on a 16-bit card.
- R4: With `card_is_32`=1 (32-bit card), traffic is any of `card_frame_n`, `card_irdy_n` or `card_req_n` at 0. The ready/interrupt line has no effect on a 32-bit card.
- R5: When a traffic input goes active, the LED is lit after the third rising clock edge. After the last synchronized traffic cycle it stays lit for exactly `HOLD_MS*CYC_PER_MS` clock cycles and then goes dark.
- R6: Traffic during a hold reloads the timer to the full period, so traffic arriving more often than once per hold period keeps the LED continuously lit.
- R7: `suspend`=1 forces every LED dark in the same cycle, with no clock edge needed.
- R8: `clk_stop_req`=1, or `pm_state` equal to 1 (D1) or 2 (D2), forces every LED dark in the same cycle. `pm_state` values 0 (D0) and 3 (D3) do not force the LEDs dark.
- R9: Any forced-dark condition empties the hold timers. After it clears, an LED stays dark until new traffic is seen.
- R10: Each socket has its own synchronizer, detector and timer. Traffic on one socket never lights another socket's LED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| card_present | input | NUM_SOCK | Card inserted, one bit per socket |
| card_powered | input | NUM_SOCK | Card supply on, one bit per socket |
| card_in_reset | input | NUM_SOCK | Card held in reset, one bit per socket |
| card_is_32 | input | NUM_SOCK | 1 = 32-bit bus card, 0 = 16-bit card |
| card_rdy_irq_n | input | NUM_SOCK | 16-bit card ready/interrupt line, active low |
| card_frame_n | input | NUM_SOCK | 32-bit card frame, active low |
| card_irdy_n | input | NUM_SOCK | 32-bit card initiator ready, active low |
| card_req_n | input | NUM_SOCK | 32-bit card bus request, active low |
| suspend | input | 1 | Suspend, forces all LEDs dark |
| clk_stop_req | input | 1 | Clock about to be stopped, forces all LEDs dark |
| pm_state | input | 2 | Function power state: 0 D0, 1 D1, 2 D2, 3 D3 |
| led | output | NUM_SOCK | Activity indicator, active high, one bit per socket |

## Verification
The hardest case to reach from the ports is the exact end of a hold that was reloaded partway through. Telling a real reload apart from the first timer simply running out needs a check placed after the first period would have ended but before the second one does. The bench drives one-cycle traffic pulses at known falling edges and then counts falling edges to the exact cycle before and after each expected turn-off. The no-resume rule is reached in a similar way. A forced-dark condition is applied in the middle of a hold and released while the old period would still be running, and the bench then confirms the LED stays dark until a new pulse arrives.

// File: rtl/sled_pkg.sv
package sled_pkg;

    typedef enum logic [1:0] {
        PM_D0 = 2'd0,
        PM_D1 = 2'd1,
        PM_D2 = 2'd2,
        PM_D3 = 2'd3
    } pm_state_e;

    typedef enum logic {
        BUS16 = 1'b0,
        BUS32 = 1'b1
    } card_bus_e;

    // One socket's raw card-side pins, grouped so they travel through the
    // synchronizer together.
    typedef struct packed {
        logic      present;
        logic      powered;
        logic      in_reset;
        card_bus_e bus;
        logic      rdy_irq_n;
        logic      frame_n;
        logic      irdy_n;
        logic      req_n;
    } sock_pins_t;

    localparam int SOCK_PINS_W = $bits(sock_pins_t);

    // Quiet value: no card, active-low lines released.
    localparam sock_pins_t SOCK_PINS_IDLE = '{
        present:   1'b0,
        powered:   1'b0,
        in_reset:  1'b1,
        bus:       BUS16,
        rdy_irq_n: 1'b1,
        frame_n:   1'b1,
        irdy_n:    1'b1,
        req_n:     1'b1
    };

    function automatic logic led_cutoff(input logic suspend_i,
                                        input logic clk_stop_i,
                                        input pm_state_e pm_i);
        return suspend_i | clk_stop_i | (pm_i == PM_D1) | (pm_i == PM_D2);
    endfunction

    function automatic logic card_live(input sock_pins_t p);
        return p.present & p.powered & ~p.in_reset;
    endfunction

    function automatic logic card_traffic(input sock_pins_t p);
        logic t;
        if (p.bus == BUS32) t = ~p.frame_n | ~p.irdy_n | ~p.req_n;
        else                t = ~p.rdy_irq_n;
        return t;
    endfunction

endpackage

// File: rtl/sled_sync.sv
module sled_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= RST_VAL;
        else     stage[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[k] <= RST_VAL;
            else     stage[k] <= stage[k-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/sled_detect.sv
module sled_detect
    import sled_pkg::*;
(
    input  sock_pins_t pins,
    output logic       live,
    output logic       traffic
);
    always_comb begin
        live    = card_live(pins);
        traffic = live & card_traffic(pins);
    end
endmodule

// File: rtl/sled_hold_timer.sv
module sled_hold_timer #(
    parameter int HOLD_CYC = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic load,
    output logic on
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD_CYC);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || clear)         remain <= '0;
        else if (load)            remain <= FULL;
        else if (remain != '0)    remain <= remain - CW'(1);
    end

    assign on = (remain != '0);
endmodule

// File: rtl/sled_ctrl.sv
module sled_ctrl
    import sled_pkg::*;
#(
    parameter int NUM_SOCK   = 2,
    parameter int CYC_PER_MS = 33000,
    parameter int HOLD_MS    = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SOCK-1:0] card_present,
    input  logic [NUM_SOCK-1:0] card_powered,
    input  logic [NUM_SOCK-1:0] card_in_reset,
    input  logic [NUM_SOCK-1:0] card_is_32,
    input  logic [NUM_SOCK-1:0] card_rdy_irq_n,
    input  logic [NUM_SOCK-1:0] card_frame_n,
    input  logic [NUM_SOCK-1:0] card_irdy_n,
    input  logic [NUM_SOCK-1:0] card_req_n,
    input  logic                suspend,
    input  logic                clk_stop_req,
    input  logic [1:0]          pm_state,
    output logic [NUM_SOCK-1:0] led
);
    localparam int HOLD_CYC = CYC_PER_MS * HOLD_MS;

    logic                cut;
    logic [NUM_SOCK-1:0] live_s;
    logic [NUM_SOCK-1:0] act_s;

    // Global dark condition acts combinationally on the outputs.
    assign cut = led_cutoff(suspend, clk_stop_req, pm_state_e'(pm_state));

    for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
        sock_pins_t raw;
        sock_pins_t synced;
        logic       lit;

        assign raw = '{
            present:   card_present[s],
            powered:   card_powered[s],
            in_reset:  card_in_reset[s],
            bus:       card_bus_e'(card_is_32[s]),
            rdy_irq_n: card_rdy_irq_n[s],
            frame_n:   card_frame_n[s],
            irdy_n:    card_irdy_n[s],
            req_n:     card_req_n[s]
        };

        sled_sync #(
            .W      (SOCK_PINS_W),
            .STAGES (2),
            .RST_VAL(SOCK_PINS_IDLE)
        ) u_sync (
            .clk(clk),
            .rst(rst),
            .d  (raw),
            .q  (synced)
        );

        sled_detect u_det (
            .pins   (synced),
            .live   (live_s[s]),
            .traffic(act_s[s])
        );

        sled_hold_timer #(
            .HOLD_CYC(HOLD_CYC)
        ) u_tmr (
            .clk  (clk),
            .rst  (rst),
            .clear(cut | ~live_s[s]),
            .load (act_s[s]),
            .on   (lit)
        );

        assign led[s] = lit & live_s[s] & ~cut;
    end
endmodule

// File: rtl/sled_ctrl_chk.sv
module sled_ctrl_chk #(
    parameter int N = 2
) (
    input logic         clk,
    input logic         rst,
    input logic         suspend,
    input logic         clk_stop_req,
    input logic [1:0]   pm_state,
    input logic [N-1:0] led,
    input logic [N-1:0] live_s,
    input logic [N-1:0] act_s
);
    logic dark;
    assign dark = suspend | clk_stop_req | (pm_state == 2'd1) | (pm_state == 2'd2);

    // R1: reset empties every timer
    a_r1_reset_dark: assert property (@(posedge clk) rst |=> (led == '0));

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r7_suspend_dark: assert property (@(posedge clk) disable iff (rst)
            suspend |-> !led[i]);

        a_r8_lowpower_dark: assert property (@(posedge clk) disable iff (rst)
            (clk_stop_req || pm_state == 2'd1 || pm_state == 2'd2) |-> !led[i]);

        a_r2_live_gate: assert property (@(posedge clk) disable iff (rst)
            !live_s[i] |-> !led[i]);

        a_r5_traffic_lights: assert property (@(posedge clk) disable iff (rst)
            (act_s[i] && !dark) |=> (led[i] || dark || !live_s[i]));

        a_r9_no_resume: assert property (@(posedge clk) disable iff (rst)
            dark |=> !led[i]);

        a_r5_rise_needs_traffic: assert property (@(posedge clk) disable iff (rst)
            $rose(led[i]) |-> $past(act_s[i]));
    end
endmodule

bind sled_ctrl sled_ctrl_chk #(.N(NUM_SOCK)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .suspend     (suspend),
    .clk_stop_req(clk_stop_req),
    .pm_state    (pm_state),
    .led         (led),
    .live_s      (live_s),
    .act_s       (act_s)
);

// File: tb/sim_sled_ctrl.sv
module sim_sled_ctrl;
    localparam int N    = 2;
    localparam int CPM  = 4;
    localparam int HMS  = 64;
    localparam int HOLD = CPM * HMS;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] present  = '1;
    logic [N-1:0] powered  = '1;
    logic [N-1:0] in_reset = '0;
    logic [N-1:0] is32     = 2'b10;
    logic [N-1:0] rdy_n    = '1;
    logic [N-1:0] frame_n  = '1;
    logic [N-1:0] irdy_n   = '1;
    logic [N-1:0] req_n    = '1;
    logic         suspend  = 1'b0;
    logic         clk_stop = 1'b0;
    logic [1:0]   pm       = 2'd0;
    logic [N-1:0] led;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sled_ctrl #(.NUM_SOCK(N), .CYC_PER_MS(CPM), .HOLD_MS(HMS)) u0 (
        .clk(clk), .rst(rst),
        .card_present(present), .card_powered(powered),
        .card_in_reset(in_reset), .card_is_32(is32),
        .card_rdy_irq_n(rdy_n), .card_frame_n(frame_n),
        .card_irdy_n(irdy_n), .card_req_n(req_n),
        .suspend(suspend), .clk_stop_req(clk_stop), .pm_state(pm),
        .led(led)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: led=%b expected %b", req, got, exp);
        end
    endtask

    // kind: 0 ready/irq, 1 frame, 2 irdy, 3 req. One-cycle pulse, ends one negedge later.
    task automatic pulse(input int s, input int kind);
        case (kind)
            0: rdy_n[s]   = 1'b0;
            1: frame_n[s] = 1'b0;
            2: irdy_n[s]  = 1'b0;
            default: req_n[s] = 1'b0;
        endcase
        step(1);
        rdy_n = '1; frame_n = '1; irdy_n = '1; req_n = '1;
    endtask

    task automatic quiet();
        suspend = 1'b1;
        step(1);
        suspend = 1'b0;
        step(3);
    endtask

    task automatic t_reset();
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 after reset", led, 2'b00);
        pulse(0, 0);
        step(5);
        rst = 1'b1;
        step(1);
        chk("R1 reset mid-hold", led, 2'b00);
        rst = 1'b0;
        step(3);
    endtask

    task automatic t_hold16();
        pulse(0, 0);
        step(2);
        chk("R5 lit on third edge", led, 2'b01);
        step(HOLD - 1);
        chk("R5 last lit cycle", led, 2'b01);
        step(1);
        chk("R5 dark after hold", led, 2'b00);
    endtask

    task automatic t_bus32();
        for (int k = 1; k < 4; k++) begin
            pulse(1, k);
            step(2);
            chk($sformatf("R4 32-bit line %0d", k), led, 2'b10);
            quiet();
        end
        pulse(1, 0);
        step(4);
        chk("R4 ready line ignored on 32-bit", led, 2'b00);
        pulse(0, 1);
        pulse(0, 2);
        pulse(0, 3);
        step(3);
        chk("R3 32-bit lines ignored on 16-bit", led, 2'b00);
        pulse(0, 0);
        step(2);
        chk("R3 ready line on 16-bit", led, 2'b01);
        quiet();
    endtask

    task automatic t_retrigger();
        logic seen_dark;
        pulse(0, 0);
        step(2);
        step(98);
        pulse(0, 0);
        step(HOLD - 64);
        chk("R6 still lit past first period", led, 2'b01);
        step(63 + 2);
        chk("R6 last lit of reloaded period", led, 2'b01);
        step(1);
        chk("R6 dark after reloaded period", led, 2'b00);
        pulse(0, 0);
        step(2);
        seen_dark = 1'b0;
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 200; c++) begin
                if (!led[0]) seen_dark = 1'b1;
                step(1);
            end
            pulse(0, 0);
        end
        chk("R6 steady traffic keeps lit", {1'b0, seen_dark}, 2'b00);
        quiet();
    endtask

    task automatic t_cutoffs();
        pulse(0, 0);
        step(10);
        suspend = 1'b1;
        #1;
        chk("R7 suspend immediate", led, 2'b00);
        step(3);
        suspend = 1'b0;
        step(5);
        chk("R9 no resume after suspend", led, 2'b00);

        pulse(1, 1);
        step(10);
        clk_stop = 1'b1;
        #1;
        chk("R8 clock-stop immediate", led, 2'b00);
        step(2);
        clk_stop = 1'b0;
        step(4);
        chk("R9 no resume after clock-stop", led, 2'b00);

        for (int p = 1; p < 3; p++) begin
            pulse(0, 0);
            step(10);
            pm = 2'(p);
            #1;
            chk($sformatf("R8 power state %0d dark", p), led, 2'b00);
            step(2);
            pm = 2'd0;
            step(4);
            chk("R9 no resume after sleep", led, 2'b00);
        end

        pm = 2'd3;
        pulse(0, 0);
        step(2);
        chk("R8 D3 does not force dark", led, 2'b01);
        pm = 2'd0;
        quiet();
        pulse(0, 0);
        step(2);
        chk("R9 new traffic relights", led, 2'b01);
        quiet();
    endtask

    task automatic t_live();
        powered[0] = 1'b0;
        step(4);
        pulse(0, 0);
        step(4);
        chk("R2 unpowered stays dark", led, 2'b00);
        powered[0] = 1'b1;
        in_reset[0] = 1'b1;
        step(4);
        pulse(0, 0);
        step(4);
        chk("R2 card in reset stays dark", led, 2'b00);
        in_reset[0] = 1'b0;
        step(4);
        pulse(0, 0);
        step(5);
        present[0] = 1'b0;
        step(3);
        chk("R2 removal during hold", led, 2'b00);
        present[0] = 1'b1;
        step(4);
        chk("R2 reinsert does not resume", led, 2'b00);
    endtask

    task automatic t_independent();
        pulse(0, 0);
        step(2);
        chk("R10 only socket 0 lit", led, 2'b01);
        quiet();
        pulse(1, 3);
        step(2);
        chk("R10 only socket 1 lit", led, 2'b10);
        quiet();
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_hold16();
        t_bus32();
        t_retrigger();
        t_cutoffs();
        t_live();
        t_independent();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule